// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This unit watches a bank of general-purpose input pins and turns level or edge activity on each of them into a latched per-pin event. Every pin owns a configuration word and a one-bit event flag. The configuration word holds an enable, a raw-detection enable, a detection mode, a polarity and a 3-bit routing target. The event flag of each pin is visible to software whether or not the pin is enabled. A pin can raise the single summary interrupt line only when it is enabled and routed to the application processor.

Each pin input passes through a two-flop synchronizer before detection. An edge is a difference between the current synchronized sample and the one before it, so a pulse shorter than a clock period can be missed. A build parameter chooses between two encodings of the mode field. The wide variant has a 2-bit mode and detects both edges in hardware. The narrow variant has a 1-bit mode, where the polarity bit picks the edge. A second parameter chooses whether writing 1 or writing 0 to an event flag acknowledges it.

Software reaches the unit over a plain valid/write/address/data bus. Reads return data with no wait states.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every configuration word and every event flag reads 0 and `irq_o` is low. Word address `2*p` selects the configuration of pin p and `2*p+1` selects its flag, which is returned in data bit 0. Configuration bits: [0] enable, [1] raw-detection enable, [3:2] mode, [4] polarity, [7:5] target.
- R2: A pin change applied before clock edge E1 becomes an edge event on E2, sets the flag on E3 and cannot set it earlier.
- R3: In level mode the flag is high exactly while the synchronized input equals the polarity bit (0 = active-low, 1 = active-high) and raw detection is on. An acknowledge write has no effect on it.
- R4: Wide variant: mode 0 = level, 1 = rising edge, 2 = falling edge, 3 = both edges. An edge flag stays set once it is latched.
- R5: Narrow variant: only mode bit 2 is stored and bit 3 reads 0. Mode bit 2 = 1 selects edge mode, with polarity 1 for rising and 0 for falling. Mode bit 2 = 0 selects level mode.
- R6: In edge mode, writing the acknowledge value to data bit 0 at a flag address clears that flag. The acknowledge value is 1 when ACK_HIGH=1 and 0 when ACK_HIGH=0. Writing the other value leaves the flag as it was.
- R7: While raw detection is off, edges set no flag. A configuration write that changes the raw-detection bit while the pin is in edge mode sets the flag, as a spurious edge.
- R8: A configuration write that changes enable from 0 to 1 on a pin in edge mode clears that pin's pending flag.
- R9: A flag can be read regardless of its pin's enable and target. `irq_o` counts only pins that are enabled and whose target equals APPS_TARGET (default 4).
- R10: `irq_o` is registered. It equals the OR over the qualified flags as they stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_PINS | Asynchronous pin inputs |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | $clog2(NUM_PINS)+1 | Pin index in the upper bits, flag/config select in bit 0 |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed word, zero wait states |
| irq_o | output | 1 | Summary interrupt to the application processor |

## Verification
The spurious event caused by a raw-detection toggle is the hardest case to bring about. It appears only when a configuration write changes that single bit on a pin already in edge mode, with the pin input held still so that no real edge can explain the flag. The stimulus clears raw detection on a quiet edge pin, acknowledges the resulting flag, then moves the pin while detection is off, and finally restores the bit. A wide instance and a narrow instance with opposite acknowledge polarity receive the same bus traffic and pin activity. The same write therefore means different modes in each, and a behavioural model follows both instances on every clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int CFG_W = 8;

  // Per-pin configuration word; packed MSB first so en lands in bit 0.
  typedef struct packed {
    logic [2:0] target;
    logic       pol;
    logic [1:0] mode;
    logic       raw_en;
    logic       en;
  } pin_cfg_t;

  typedef enum logic [1:0] {
    DET_LEVEL = 2'd0,
    DET_RISE  = 2'd1,
    DET_FALL  = 2'd2,
    DET_BOTH  = 2'd3
  } det_kind_t;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (sync_o == $past(async_i, 2))); // R2

endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
  import gpio_irq_pkg::*;
#(
  parameter int MODE_W  = 2,
  parameter bit ACK_VAL = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     smp_i,
  input  logic     cfg_we_i,
  input  pin_cfg_t cfg_wdata_i,
  input  logic     st_we_i,
  input  logic     st_wbit_i,
  output pin_cfg_t cfg_o,
  output logic     status_o
);

  pin_cfg_t  cfg_q;
  pin_cfg_t  cfg_store;
  det_kind_t kind;
  logic      prev_q;
  logic      status_q;
  logic      status_d;
  logic      is_edge;
  logic      rise;
  logic      fall;
  logic      edge_evt;
  logic      glitch;
  logic      clear_req;
  logic      en_rise;
  logic      level_act;

  // Mode decode: the variant is picked by MODE_W.
  if (MODE_W == 2) begin : g_wide
    always_comb begin
      case (cfg_q.mode)
        2'd0:    kind = DET_LEVEL;
        2'd1:    kind = DET_RISE;
        2'd2:    kind = DET_FALL;
        default: kind = DET_BOTH;
      endcase
    end
    always_comb begin
      cfg_store = cfg_wdata_i;
    end
  end else begin : g_narrow
    always_comb begin
      if (!cfg_q.mode[0])  kind = DET_LEVEL;
      else if (cfg_q.pol)  kind = DET_RISE;
      else                 kind = DET_FALL;
    end
    always_comb begin
      cfg_store      = cfg_wdata_i;
      cfg_store.mode = {1'b0, cfg_wdata_i.mode[0]};
    end
  end

  assign is_edge   = (kind != DET_LEVEL);
  assign rise      = smp_i & ~prev_q;
  assign fall      = ~smp_i & prev_q;
  assign level_act = cfg_q.raw_en & (smp_i == cfg_q.pol);
  assign glitch    = cfg_we_i & (cfg_wdata_i.raw_en != cfg_q.raw_en);
  assign en_rise   = cfg_we_i & cfg_wdata_i.en & ~cfg_q.en;
  assign clear_req = (st_we_i & (st_wbit_i == ACK_VAL)) | en_rise;

  always_comb begin
    edge_evt = 1'b0;
    if (cfg_q.raw_en) begin
      case (kind)
        DET_RISE: edge_evt = rise;
        DET_FALL: edge_evt = fall;
        DET_BOTH: edge_evt = rise | fall;
        default:  edge_evt = 1'b0;
      endcase
    end
  end

  always_comb begin
    if (!is_edge) status_d = level_act;
    else          status_d = (status_q & ~clear_req) | edge_evt | glitch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      prev_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      prev_q   <= smp_i;
      status_q <= status_d;
      if (cfg_we_i) cfg_q <= cfg_store;
    end
  end

  assign cfg_o    = cfg_q;
  assign status_o = status_q;

  AST_EDGE_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (is_edge && status_q && !st_we_i && !cfg_we_i) |=> status_q); // R4

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (is_edge && st_we_i && (st_wbit_i == ACK_VAL) && !edge_evt && !cfg_we_i) |=> !status_q); // R6

  AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
    (!is_edge && !cfg_we_i && !level_act) |=> !status_q); // R3

  AST_RAW_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (is_edge && !cfg_q.raw_en && !status_q && !cfg_we_i) |=> !status_q); // R7

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int       NUM_PINS    = 8,
  parameter int       MODE_W      = 2,
  parameter bit       ACK_HIGH    = 1'b1,
  parameter bit [2:0] APPS_TARGET = 3'd4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_PINS-1:0]             pins_i,
  input  logic                            bus_valid_i,
  input  logic                            bus_write_i,
  input  logic [$clog2(NUM_PINS):0]       bus_addr_i,
  input  logic [7:0]                      bus_wdata_i,
  output logic [7:0]                      bus_rdata_o,
  output logic                            irq_o
);

  localparam int PIN_W  = $clog2(NUM_PINS);
  localparam int ADDR_W = PIN_W + 1;

  logic [NUM_PINS-1:0] smp;
  logic [NUM_PINS-1:0] status;
  logic [NUM_PINS-1:0] eligible;
  logic [NUM_PINS-1:0] qual;
  pin_cfg_t            cfg [NUM_PINS];
  logic [PIN_W-1:0]    idx;
  logic                sel_flag;
  logic                wr;
  logic                irq_q;

  assign idx      = bus_addr_i[ADDR_W-1:1];
  assign sel_flag = bus_addr_i[0];
  assign wr       = bus_valid_i & bus_write_i;

  gpio_irq_sync #(.WIDTH(NUM_PINS)) i_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pins_i),
    .sync_o  (smp)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic hit;
    assign hit = wr & (idx == PIN_W'(p));

    gpio_irq_cell #(.MODE_W(MODE_W), .ACK_VAL(ACK_HIGH)) i_cell (
      .clk         (clk),
      .rst         (rst),
      .smp_i       (smp[p]),
      .cfg_we_i    (hit & ~sel_flag),
      .cfg_wdata_i (pin_cfg_t'(bus_wdata_i)),
      .st_we_i     (hit & sel_flag),
      .st_wbit_i   (bus_wdata_i[0]),
      .cfg_o       (cfg[p]),
      .status_o    (status[p])
    );

    assign eligible[p] = cfg[p].en & (cfg[p].target == APPS_TARGET);
    assign qual[p]     = status[p] & eligible[p];
  end

  // Zero-wait read of the addressed word.
  always_comb begin
    bus_rdata_o = '0;
    if (int'(idx) < NUM_PINS) begin
      if (sel_flag) bus_rdata_o = {7'd0, status[idx]};
      else          bus_rdata_o = cfg[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |qual;
  end

  assign irq_o = irq_q;

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(|qual)); // R10

  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_o) |-> !$past(|qual)); // R10

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (eligible == '0) |=> !irq_o); // R9

endmodule

// File: tb/test_gpio_irq_unit.sv
`timescale 1ns/100ps
module test_gpio_irq_unit;

  localparam int NP = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [NP-1:0] pins = '0;
  logic       bus_valid = 1'b0;
  logic       bus_write = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] rdata [2];
  logic       irq [2];

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  gpio_irq_unit #(.NUM_PINS(NP), .MODE_W(2), .ACK_HIGH(1'b1), .APPS_TARGET(3'd4)) i_gpio_irq_unit (
    .clk(clk), .rst(rst), .pins_i(pins), .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata[0]), .irq_o(irq[0]));

  gpio_irq_unit #(.NUM_PINS(NP), .MODE_W(1), .ACK_HIGH(1'b0), .APPS_TARGET(3'd4)) i_gpio_irq_unit_narrow (
    .clk(clk), .rst(rst), .pins_i(pins), .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata[1]), .irq_o(irq[1]));

  // ---------------- behavioural reference model ----------------
  bit       ms1 [NP];
  bit       ms2 [NP];
  bit       mpv [NP];
  bit [7:0] mcfg [2][NP];
  bit       mst  [2][NP];
  bit       mirq [2];

  function automatic int kind_of(int k, bit [7:0] c);
    if (k == 0) return int'(c[3:2]);
    if (!c[2]) return 0;
    return c[4] ? 1 : 2;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NP; p++) begin
        ms1[p] = 0; ms2[p] = 0; mpv[p] = 0;
        for (int k = 0; k < 2; k++) begin mcfg[k][p] = 0; mst[k][p] = 0; end
      end
      mirq[0] = 0; mirq[1] = 0;
    end else begin
      for (int k = 0; k < 2; k++) begin
        bit any;
        any = 0;
        for (int p = 0; p < NP; p++)
          if (mst[k][p] && mcfg[k][p][0] && mcfg[k][p][7:5] == 3'd4) any = 1;
        mirq[k] = any;
        for (int p = 0; p < NP; p++) begin
          bit [7:0] c;
          bit hit, cw, sw, rs, fl, ev, clr;
          int kd;
          c  = mcfg[k][p];
          kd = kind_of(k, c);
          hit = bus_valid && bus_write && (int'(bus_addr[2:1]) == p);
          cw = hit && !bus_addr[0];
          sw = hit && bus_addr[0];
          rs = ms2[p] && !mpv[p];
          fl = !ms2[p] && mpv[p];
          if (kd == 0) mst[k][p] = c[1] && (ms2[p] == c[4]);
          else begin
            ev  = c[1] && ((kd == 1 && rs) || (kd == 2 && fl) || (kd == 3 && (rs || fl)));
            clr = (sw && bus_wdata[0] == (k == 0)) || (cw && bus_wdata[0] && !c[0]);
            mst[k][p] = (mst[k][p] && !clr) || ev || (cw && bus_wdata[1] != c[1]);
          end
          if (cw) mcfg[k][p] = (k == 0) ? bus_wdata : (bus_wdata & 8'hF7);
        end
      end
      for (int p = 0; p < NP; p++) begin
        mpv[p] = ms2[p]; ms2[p] = ms1[p]; ms1[p] = pins[p];
      end
    end
  end

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (!rst) begin
      for (int k = 0; k < 2; k++) begin
        bit [7:0] er;
        er = bus_addr[0] ? {7'd0, mst[k][bus_addr[2:1]]} : mcfg[k][bus_addr[2:1]];
        checks++;
        if (irq[k] !== mirq[k]) begin
          fails++;
          $display("FAIL R10 inst%0d irq act=%0h exp=%0h t=%0t", k, irq[k], mirq[k], $time);
        end
        checks++;
        if (rdata[k] !== er) begin
          fails++;
          $display("FAIL R9 inst%0d read act=%0h exp=%0h t=%0t", k, rdata[k], er, $time);
        end
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(posedge clk); #1;
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd2(logic [2:0] a, string tag, logic [7:0] e0, logic [7:0] e1);
    bus_addr = a;
    @(negedge clk);
    chk({tag, " wide"}, rdata[0], e0);
    chk({tag, " narrow"}, rdata[1], e1);
  endtask

  task automatic setpin(int p, bit v);
    @(posedge clk); #1;
    pins[p] = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(100000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(4);
    rst = 0;
    idle(1);
    // R1: reset values
    rd2(3'd0, "R1 cfg0", 8'h00, 8'h00);
    rd2(3'd1, "R1 flag0", 8'h00, 8'h00);
    chk("R1 irq", {7'd0, irq[0]}, 8'h00);

    // Pin0 rising in both variants
    wr(3'd0, 8'h97);
    setpin(0, 1); idle(5);
    rd2(3'd1, "R4 R5 rise", 8'h01, 8'h01);

    // R6: ack polarity differs between instances
    wr(3'd1, 8'h01);
    rd2(3'd1, "R6 ack1", 8'h00, 8'h01);
    wr(3'd1, 8'h00);
    rd2(3'd1, "R6 ack0", 8'h00, 8'h00);

    setpin(0, 0); idle(5);
    rd2(3'd1, "R4 no fall in rise mode", 8'h00, 8'h00);

    // R2 / R10 latency
    setpin(0, 1);
    bus_addr = 3'd1;
    @(negedge clk);
    @(negedge clk);
    chk("R2 after E1", rdata[0], 8'h00);
    @(negedge clk);
    chk("R2 after E2", rdata[0], 8'h00);
    @(negedge clk);
    chk("R2 after E3", rdata[0], 8'h01);
    chk("R10 irq not yet", {7'd0, irq[0]}, 8'h00);
    @(negedge clk);
    chk("R10 irq one later", {7'd0, irq[0]}, 8'h01);
    wr(3'd1, 8'h01);
    wr(3'd1, 8'h00);

    // Pin1: wide falling, narrow stores 0x93 = level active-high
    wr(3'd2, 8'h9B);
    rd2(3'd2, "R5 bit3 dropped", 8'h9B, 8'h93);
    setpin(1, 1); idle(5);
    rd2(3'd3, "R3 R4 pin1 high", 8'h00, 8'h01);
    setpin(1, 0); idle(5);
    rd2(3'd3, "R3 R4 pin1 low", 8'h01, 8'h00);
    wr(3'd3, 8'h01);

    // Pin2 level active-low, ack ignored
    wr(3'd4, 8'h83);
    idle(4);
    rd2(3'd5, "R3 active low", 8'h01, 8'h01);
    wr(3'd5, 8'h01);
    wr(3'd5, 8'h00);
    rd2(3'd5, "R3 ack ignored", 8'h01, 8'h01);
    setpin(2, 1); idle(5);
    rd2(3'd5, "R3 level gone", 8'h00, 8'h00);

    // Pin3: wide both edges, narrow rising
    wr(3'd6, 8'h9F);
    setpin(3, 1); idle(5);
    rd2(3'd7, "R4 R5 pin3 rise", 8'h01, 8'h01);
    wr(3'd7, 8'h01);
    wr(3'd7, 8'h00);
    setpin(3, 0); idle(5);
    rd2(3'd7, "R4 R5 pin3 fall", 8'h01, 8'h00);

    // R9 routing and masking
    wr(3'd6, 8'h5F);
    idle(2);
    rd2(3'd7, "R9 flag kept other target", 8'h01, 8'h00);
    chk("R9 irq other target", {7'd0, irq[0]}, 8'h00);
    wr(3'd6, 8'h9E);
    idle(2);
    rd2(3'd7, "R9 flag kept disabled", 8'h01, 8'h00);
    chk("R9 irq disabled", {7'd0, irq[0]}, 8'h00);

    // R8 re-enable clears pending
    wr(3'd6, 8'h9F);
    rd2(3'd7, "R8 rearm clears", 8'h00, 8'h00);

    // R7 raw-detection toggle
    wr(3'd6, 8'h9D);
    rd2(3'd7, "R7 toggle off", 8'h01, 8'h01);
    wr(3'd7, 8'h01);
    wr(3'd7, 8'h00);
    setpin(3, 1); idle(5);
    rd2(3'd7, "R7 raw off no event", 8'h00, 8'h00);
    wr(3'd6, 8'h9F);
    rd2(3'd7, "R7 toggle on", 8'h01, 8'h01);
    idle(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule